// File: doc/BRIEF.md
# Duplicate-Result Value Lookup CAM

This block is a small fully associative table that maps result values back to the physical register tags that currently hold them. An out-of-order core presents an instruction's result on the lookup port after execution. A hit returns the tag of the register that already holds that value, so the core can release the register it freshly allocated and reuse the existing one. The caller's own tag is not recorded on a hit.

When a unique value is written to a register, the core records the (value, tag) pair on the add port. When a register is freed, the core removes its entries on the invalidate port. The lookup answer is combinational. A registered copy of that answer is also provided for a pipelined consumer. Rename map updates and the rebroadcast to dependent instructions live outside this block.

Top module: `val_lookup_cam`

## Requirements
- R1: After reset the table is empty: every lookup misses, and the registered hit and tag outputs read 0.
- R2: While `lk_valid_i` is high and a valid entry holds `lk_value_i`, `lk_hit_o` is 1 in the same cycle and `lk_tag_o` carries that entry's tag.
- R3: `lk_hit_o` is 0, and `lk_tag_o` is 0, when `lk_valid_i` is low or no valid entry holds the value.
- R4: After an add of (V, T), a lookup of V in the next cycle hits with tag T.
- R5: An invalidate of tag T removes every entry holding T. From the next cycle no lookup returns T, unless T was added again.
- R6: An add and an invalidate in the same cycle apply the invalidate first. An add whose tag equals the invalidated tag is kept, and a slot freed by the invalidate can take the add.
- R7: An add of a value that is already stored overwrites that entry's tag and creates no second entry. At most one entry matches any value.
- R8: An add of a new value goes into the lowest-index empty slot. If no slot is empty, it replaces the slot under a replacement pointer. The pointer is 0 after reset and advances by one, wrapping past the last entry, only on each replacement.
- R9: `lk_hit_q_o` and `lk_tag_q_o` equal `lk_hit_o` and `lk_tag_o` of the previous cycle.
- R10: A lookup sees the table as it was before the adds and invalidates issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_value_i | input | VAL_W | Value to search for |
| lk_hit_o | output | 1 | Combinational hit |
| lk_tag_o | output | TAG_W | Tag of the matching entry (0 on a miss) |
| lk_hit_q_o | output | 1 | Hit, registered one cycle |
| lk_tag_q_o | output | TAG_W | Tag, registered one cycle |
| add_valid_i | input | 1 | Record a pair |
| add_value_i | input | VAL_W | Value to record |
| add_tag_i | input | TAG_W | Register tag holding the value |
| inv_valid_i | input | 1 | Remove the entries of a tag |
| inv_tag_i | input | TAG_W | Tag whose entries are removed |

## Verification
Random traffic draws values from a small pool, so lookups hit and miss in roughly equal measure and adds often repeat a stored value. This separates the update-in-place path from the insert path. Invalidate tags are drawn from a narrow range, so they collide with stored tags and with the tag of a same-cycle add, which exposes the wrong apply order. A directed fill of all entries followed by extra adds shows whether the eviction order follows the pointer rather than some other slot. A lookup of a value that is being added in the same cycle tells pre-update visibility apart from bypassing the add.

// File: rtl/val_cam_pkg.sv
package val_cam_pkg;
  typedef enum logic [1:0] {
    ADD_NONE  = 2'd0,
    ADD_UPD   = 2'd1,
    ADD_FREE  = 2'd2,
    ADD_EVICT = 2'd3
  } add_kind_e;
endpackage

// File: rtl/val_cam_prio.sv
module val_cam_prio #(
  parameter int N     = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/val_cam_match.sv
module val_cam_match #(
  parameter int ENTRIES = 16,
  parameter int VAL_W   = 64
) (
  input  logic [ENTRIES-1:0]            vld_i,
  input  logic [ENTRIES-1:0][VAL_W-1:0] val_i,
  input  logic [VAL_W-1:0]              key_i,
  output logic [ENTRIES-1:0]            match_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = vld_i[g] && (val_i[g] == key_i);
  end
endmodule

// File: rtl/val_cam_rr.sv
module val_cam_rr #(
  parameter int N     = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == IDX_W'(N - 1)) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/val_lookup_cam.sv
module val_lookup_cam #(
  parameter int VAL_W   = 64,
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 7,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [VAL_W-1:0] lk_value_i,
  output logic             lk_hit_o,
  output logic [TAG_W-1:0] lk_tag_o,
  output logic             lk_hit_q_o,
  output logic [TAG_W-1:0] lk_tag_q_o,
  input  logic             add_valid_i,
  input  logic [VAL_W-1:0] add_value_i,
  input  logic [TAG_W-1:0] add_tag_i,
  input  logic             inv_valid_i,
  input  logic [TAG_W-1:0] inv_tag_i
);
  import val_cam_pkg::*;

  logic [ENTRIES-1:0]            vld_q;
  logic [ENTRIES-1:0][VAL_W-1:0] val_q;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;

  logic [ENTRIES-1:0] lk_match, inv_hit, vld_post_inv, add_match;
  logic               lk_any, upd_any, free_any;
  logic [IDX_W-1:0]   lk_idx, upd_idx, free_idx, rr_ptr, wr_idx;
  add_kind_e          add_kind;

  // lookup against pre-update state
  val_cam_match #(.ENTRIES(ENTRIES), .VAL_W(VAL_W)) u_lk_match (
    .vld_i(vld_q), .val_i(val_q), .key_i(lk_value_i), .match_o(lk_match)
  );
  val_cam_prio #(.N(ENTRIES)) u_lk_prio (
    .req_i(lk_match), .any_o(lk_any), .idx_o(lk_idx)
  );

  assign lk_hit_o = lk_valid_i && lk_any;
  assign lk_tag_o = lk_hit_o ? tag_q[lk_idx] : '0;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_inv
    assign inv_hit[g] = inv_valid_i && vld_q[g] && (tag_q[g] == inv_tag_i);
  end
  assign vld_post_inv = vld_q & ~inv_hit;

  // add sees the table after this cycle's invalidate
  val_cam_match #(.ENTRIES(ENTRIES), .VAL_W(VAL_W)) u_add_match (
    .vld_i(vld_post_inv), .val_i(val_q), .key_i(add_value_i), .match_o(add_match)
  );
  val_cam_prio #(.N(ENTRIES)) u_upd_prio (
    .req_i(add_match), .any_o(upd_any), .idx_o(upd_idx)
  );
  val_cam_prio #(.N(ENTRIES)) u_free_prio (
    .req_i(~vld_post_inv), .any_o(free_any), .idx_o(free_idx)
  );

  always_comb begin
    if (!add_valid_i)  add_kind = ADD_NONE;
    else if (upd_any)  add_kind = ADD_UPD;
    else if (free_any) add_kind = ADD_FREE;
    else               add_kind = ADD_EVICT;
  end

  always_comb begin
    unique case (add_kind)
      ADD_UPD:  wr_idx = upd_idx;
      ADD_FREE: wr_idx = free_idx;
      default:  wr_idx = rr_ptr;
    endcase
  end

  val_cam_rr #(.N(ENTRIES)) u_rr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(add_kind == ADD_EVICT), .ptr_o(rr_ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      val_q <= '0;
      tag_q <= '0;
    end else begin
      vld_q <= vld_post_inv;
      if (add_kind != ADD_NONE) begin
        vld_q[wr_idx] <= 1'b1;
        val_q[wr_idx] <= add_value_i;
        tag_q[wr_idx] <= add_tag_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_hit_q_o <= 1'b0;
      lk_tag_q_o <= '0;
    end else begin
      lk_hit_q_o <= lk_hit_o;
      lk_tag_q_o <= lk_tag_o;
    end
  end
endmodule

// File: rtl/val_lookup_cam_chk.sv
module val_lookup_cam_chk #(
  parameter int VAL_W   = 64,
  parameter int ENTRIES = 16,
  parameter int TAG_W   = 7
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lk_valid_i,
  input logic [VAL_W-1:0]   lk_value_i,
  input logic               lk_hit_o,
  input logic [TAG_W-1:0]   lk_tag_o,
  input logic               lk_hit_q_o,
  input logic [TAG_W-1:0]   lk_tag_q_o,
  input logic               add_valid_i,
  input logic [VAL_W-1:0]   add_value_i,
  input logic [TAG_W-1:0]   add_tag_i,
  input logic               inv_valid_i,
  input logic [TAG_W-1:0]   inv_tag_i,
  input logic [ENTRIES-1:0] lk_match
);
  logic run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  p_first_empty_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (!lk_hit_o && !lk_hit_q_o && lk_tag_q_o == '0));

  p_idle_miss_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> (!lk_hit_o && lk_tag_o == '0));

  p_add_seen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && add_valid_i) |=>
      (!(lk_valid_i && lk_value_i == $past(add_value_i)) ||
       (lk_hit_o && lk_tag_o == $past(add_tag_i))));

  p_inv_gone_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && inv_valid_i && !add_valid_i) |=>
      !(lk_hit_o && lk_tag_o == $past(inv_tag_i)));

  p_single_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match));

  p_reg_copy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> (lk_hit_q_o == $past(lk_hit_o) && lk_tag_q_o == $past(lk_tag_o)));
endmodule

bind val_lookup_cam val_lookup_cam_chk #(
  .VAL_W(VAL_W), .ENTRIES(ENTRIES), .TAG_W(TAG_W)
) u_chk (.*);

// File: tb/val_lookup_cam_test.sv
module val_lookup_cam_test;
  localparam int VW = 64;
  localparam int NE = 16;
  localparam int TW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          lk_valid = 1'b0;
  logic [VW-1:0] lk_value = '0;
  logic          lk_hit, lk_hit_q;
  logic [TW-1:0] lk_tag, lk_tag_q;
  logic          add_valid = 1'b0;
  logic [VW-1:0] add_value = '0;
  logic [TW-1:0] add_tag = '0;
  logic          inv_valid = 1'b0;
  logic [TW-1:0] inv_tag = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference table
  bit            m_vld [NE];
  logic [VW-1:0] m_val [NE];
  logic [TW-1:0] m_tag [NE];
  int            m_ptr;

  always #2 clk = ~clk;

  val_lookup_cam #(.VAL_W(VW), .ENTRIES(NE), .TAG_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_value_i(lk_value),
    .lk_hit_o(lk_hit), .lk_tag_o(lk_tag),
    .lk_hit_q_o(lk_hit_q), .lk_tag_q_o(lk_tag_q),
    .add_valid_i(add_valid), .add_value_i(add_value), .add_tag_i(add_tag),
    .inv_valid_i(inv_valid), .inv_tag_i(inv_tag)
  );

  task automatic check(input string req, input string what,
                       input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void model_lookup(input bit lv, input logic [VW-1:0] v,
                                       output bit h, output logic [TW-1:0] t);
    h = 1'b0;
    t = '0;
    if (lv)
      for (int i = 0; i < NE; i++)
        if (!h && m_vld[i] && m_val[i] == v) begin
          h = 1'b1;
          t = m_tag[i];
        end
  endfunction

  function automatic void model_update(input bit av, input logic [VW-1:0] v,
                                       input logic [TW-1:0] t, input bit iv,
                                       input logic [TW-1:0] it);
    int idx = -1;
    if (iv)
      for (int i = 0; i < NE; i++)
        if (m_vld[i] && m_tag[i] == it) m_vld[i] = 1'b0;
    if (!av) return;
    for (int i = 0; i < NE; i++)
      if (idx < 0 && m_vld[i] && m_val[i] == v) idx = i;
    if (idx < 0)
      for (int i = 0; i < NE; i++)
        if (idx < 0 && !m_vld[i]) idx = i;
    if (idx < 0) begin
      idx = m_ptr;
      m_ptr = (m_ptr == NE - 1) ? 0 : m_ptr + 1;
    end
    m_vld[idx] = 1'b1;
    m_val[idx] = v;
    m_tag[idx] = t;
  endfunction

  task automatic step(input string req, input bit lv, input logic [VW-1:0] lval,
                      input bit av, input logic [VW-1:0] aval, input logic [TW-1:0] atag,
                      input bit iv, input logic [TW-1:0] itag);
    bit eh;
    logic [TW-1:0] et;
    @(negedge clk);
    lk_valid = lv; lk_value = lval;
    add_valid = av; add_value = aval; add_tag = atag;
    inv_valid = iv; inv_tag = itag;
    #1;
    model_lookup(lv, lval, eh, et);
    check(req, "hit", VW'(lk_hit), VW'(eh));
    check(req, "tag", VW'(lk_tag), VW'(et));
    @(posedge clk);
    model_update(av, aval, atag, iv, itag);
    #1;
    check("R9", "hit_q", VW'(lk_hit_q), VW'(eh));
    check("R9", "tag_q", VW'(lk_tag_q), VW'(et));
  endtask

  task automatic look(input string req, input logic [VW-1:0] v);
    step(req, 1'b1, v, 1'b0, '0, '0, 1'b0, '0);
  endtask

  function automatic logic [VW-1:0] pool_val(input int k);
    return {32'hA5C3_0000 + 32'(k), 32'(k * 7)};
  endfunction

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NE; i++) begin
      m_vld[i] = 1'b0; m_val[i] = '0; m_tag[i] = '0;
    end
    m_ptr = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "hit_q in reset", VW'(lk_hit_q), '0);
    check("R1", "tag_q in reset", VW'(lk_tag_q), '0);
    rst_n = 1'b1;

    // R1 empty after reset; R3 idle lookup
    look("R1", pool_val(0));
    step("R3", 1'b0, pool_val(0), 1'b0, '0, '0, 1'b0, '0);

    // R4/R2 add then hit
    step("R4", 1'b0, '0, 1'b1, 64'h1234, 7'd9, 1'b0, '0);
    look("R2", 64'h1234);
    step("R3", 1'b0, 64'h1234, 1'b0, '0, '0, 1'b0, '0);
    look("R3", 64'h1235);

    // R10 lookup of a value added in the same cycle misses
    step("R10", 1'b1, 64'h777, 1'b1, 64'h777, 7'd3, 1'b0, '0);
    look("R4", 64'h777);

    // R7 re-add of a stored value overwrites its tag
    step("R7", 1'b0, '0, 1'b1, 64'h1234, 7'd44, 1'b0, '0);
    look("R7", 64'h1234);

    // R5 invalidate removes all entries with a tag
    step("R5", 1'b0, '0, 1'b1, 64'h888, 7'd44, 1'b0, '0);
    step("R5", 1'b0, '0, 1'b0, '0, '0, 1'b1, 7'd44);
    look("R5", 64'h1234);
    look("R5", 64'h888);
    look("R5", 64'h777);

    // R6 same-cycle invalidate and add of the same tag: add survives
    step("R6", 1'b0, '0, 1'b1, 64'h999, 7'd3, 1'b1, 7'd3);
    look("R6", 64'h999);
    look("R6", 64'h777);

    // R8 fill every slot, then evictions follow the pointer
    step("R8", 1'b0, '0, 1'b0, '0, '0, 1'b1, 7'd3);
    for (int i = 0; i < NE; i++)
      step("R8", 1'b0, '0, 1'b1, 64'h5000 + 64'(i), TW'(i), 1'b0, '0);
    step("R8", 1'b0, '0, 1'b1, 64'h6000, 7'd100, 1'b0, '0);
    look("R8", 64'h5000);
    look("R8", 64'h5001);
    step("R8", 1'b0, '0, 1'b1, 64'h6001, 7'd101, 1'b0, '0);
    look("R8", 64'h5001);
    look("R8", 64'h5002);
    // R6 freed slot takes the add when the table is full
    step("R6", 1'b0, '0, 1'b1, 64'h6002, 7'd102, 1'b1, 7'd9);
    look("R6", 64'h5009);
    look("R6", 64'h5002);
    look("R6", 64'h6002);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      bit lv = ($urandom % 4) != 0;
      bit av = ($urandom % 3) == 0;
      bit iv = ($urandom % 5) == 0;
      step("R2", lv, pool_val($urandom % 24), av, pool_val($urandom % 24),
           TW'($urandom % 20), iv, TW'($urandom % 20));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule